// File: doc/BRIEF.md
# Out-of-Order Commit Grant Tracker

This block decides which reorder-buffer entries may retire in a core whose reorder buffer never compacts. Entries are written into any free slot. Their relative age is held in an N×N age matrix: a one at row i, column j means that entry j is older than entry i. A per-entry flag marks instructions that might still fault or mispredict. An entry may retire as soon as three things hold: it has finished, its own flag is clear, and no older entry still carries the flag. It does not have to be at the head of the buffer.

The same matrix serves two other jobs. It finds the single oldest live entry, which is where a pending exception is raised when nothing can retire. It also gives the set of entries younger than a mispredicting instruction, which must be discarded.

The block receives dispatch, completion, resolve-safe and squash events by entry index. It returns three registered vectors: the retire grants, the one-hot oldest entry, and the squash kill mask.

Top module: `ctg_commit_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, all entries become empty, and `commit_grant`, `oldest_oh` and `kill_mask` read zero after that edge.
- R2: A dispatch slot marks its index as a live entry that is younger than every entry already live. When several slots dispatch in one cycle, a lower slot number is older than a higher one. The index is given as the binary value in bits [s*IDX_W +: IDX_W] of `disp_idx`.
- R3: A live entry is eligible to retire when three conditions hold: it has completed, its own speculative flag is clear, and no older live entry has its speculative flag set. Its position relative to other entries does not matter. Its `commit_grant` bit rises after the second rising edge counted from the edge that samples the enabling event.
- R4: At most CMT_W grants are issued per cycle. Among the eligible entries, those with the lowest index are chosen first.
- R5: A granted entry leaves the tracker at the same edge that raises its grant bit. It is never granted again and never reported as oldest until it is dispatched anew.
- R6: A resolve-safe event clears the speculative flag of its index. This lets younger completed entries retire.
- R7: `oldest_oh` is one-hot on the oldest live entry, or zero when the tracker is empty. It reflects the state before the edge that loads it.
- R8: On a squash of index c, `kill_mask` after that edge holds every live entry younger than c. It also holds c itself when `sq_self` is 1. All of these entries are removed.
- R9: An entry that is being killed is not granted in the same cycle. Older eligible entries are still granted in that cycle.
- R10: Dispatches presented in a cycle with `sq_vld` high are ignored.
- R11: A completion event for an index that is not live is ignored. It does not make that index eligible after a later dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_vld | input | DISP_W | Dispatch slot valid |
| disp_idx | input | DISP_W*IDX_W | Entry index per dispatch slot |
| disp_spec | input | DISP_W | Dispatched instruction may fault or mispredict |
| safe_vld | input | SAFE_W | Resolve-safe port valid |
| safe_idx | input | SAFE_W*IDX_W | Entry index per resolve-safe port |
| done_vld | input | DONE_W | Completion port valid |
| done_idx | input | DONE_W*IDX_W | Entry index per completion port |
| sq_vld | input | 1 | Squash request |
| sq_idx | input | IDX_W | Mispredicting entry |
| sq_self | input | 1 | Also discard the mispredicting entry itself |
| commit_grant | output | N | Entries retired at the last edge |
| oldest_oh | output | N | One-hot oldest live entry |
| kill_mask | output | N | Entries discarded by the last squash |

## Verification
The bench builds the block with its defaults: eight entries, two dispatch slots, two completion and two resolve-safe ports, and a retire width of two.

With only eight slots, random traffic reuses every index many times. As a result, age order soon has nothing to do with index order, so stale matrix bits and out-of-head retirement are exercised constantly. A retire width of two is smaller than the number of entries that are often eligible together, so the lowest-index cap is reached routinely. Two dispatch slots make same-cycle age ordering a common case.

The reference model tracks age with sequence numbers, not with a matrix.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
  // per-entry status held by the tracker
  typedef struct packed {
    logic vld;
    logic done;
    logic spec;
  } ctg_ent_t;
endpackage

// File: rtl/ctg_age_matrix.sv
module ctg_age_matrix #(
  parameter int N      = 8,
  parameter int DISP_W = 2,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N-1:0]              base_vld,
  input  logic [DISP_W-1:0]         disp_en,
  input  logic [DISP_W*IDX_W-1:0]   disp_idx,
  output logic [N-1:0][N-1:0]       row
);
  logic [N-1:0][N-1:0] mat_q, mat_n;
  logic [N-1:0]        acc;
  logic [IDX_W-1:0]    d_sel;

  // rows: bit j set means j older than this entry
  always_comb begin
    mat_n = mat_q;
    acc   = base_vld;
    d_sel = '0;
    for (int s = 0; s < DISP_W; s++) begin
      if (disp_en[s]) begin
        d_sel = disp_idx[s*IDX_W +: IDX_W];
        for (int r = 0; r < N; r++) mat_n[r][d_sel] = 1'b0;
        mat_n[d_sel]        = acc;
        mat_n[d_sel][d_sel] = 1'b0;
        acc[d_sel]          = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mat_q <= '0;
    else     mat_q <= mat_n;
  end

  assign row = mat_q;
endmodule

// File: rtl/ctg_grant_select.sv
module ctg_grant_select #(
  parameter int N     = 8,
  parameter int CMT_W = 2
) (
  input  logic [N-1:0][N-1:0] row,
  input  logic [N-1:0]        vld,
  input  logic [N-1:0]        done,
  input  logic [N-1:0]        spec,
  input  logic [N-1:0]        block,
  output logic [N-1:0]        grant
);
  logic [N-1:0] elig;
  int unsigned  cnt;

  always_comb begin
    for (int i = 0; i < N; i++)
      elig[i] = vld[i] & done[i] & ~spec[i] & ~block[i] & ~|(row[i] & spec);
  end

  always_comb begin
    grant = '0;
    cnt   = 0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && cnt < CMT_W) begin
        grant[i] = 1'b1;
        cnt      = cnt + 1;
      end
    end
  end
endmodule

// File: rtl/ctg_squash_scan.sv
module ctg_squash_scan #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0][N-1:0] row,
  input  logic [N-1:0]        vld,
  input  logic                sq_vld,
  input  logic [IDX_W-1:0]    sq_idx,
  input  logic                sq_self,
  output logic [N-1:0]        kill,
  output logic [N-1:0]        oldest
);
  always_comb begin
    kill = '0;
    if (sq_vld) begin
      for (int r = 0; r < N; r++) kill[r] = row[r][sq_idx] & vld[r];
      if (sq_self) kill[sq_idx] = vld[sq_idx];
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) oldest[i] = vld[i] & ~|(row[i] & vld);
  end
endmodule

// File: rtl/ctg_commit_tracker.sv
module ctg_commit_tracker #(
  parameter int N      = 8,
  parameter int DISP_W = 2,
  parameter int SAFE_W = 2,
  parameter int DONE_W = 2,
  parameter int CMT_W  = 2,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DISP_W-1:0]       disp_vld,
  input  logic [DISP_W*IDX_W-1:0] disp_idx,
  input  logic [DISP_W-1:0]       disp_spec,
  input  logic [SAFE_W-1:0]       safe_vld,
  input  logic [SAFE_W*IDX_W-1:0] safe_idx,
  input  logic [DONE_W-1:0]       done_vld,
  input  logic [DONE_W*IDX_W-1:0] done_idx,
  input  logic                    sq_vld,
  input  logic [IDX_W-1:0]        sq_idx,
  input  logic                    sq_self,
  output logic [N-1:0]            commit_grant,
  output logic [N-1:0]            oldest_oh,
  output logic [N-1:0]            kill_mask
);
  import ctg_pkg::*;

  ctg_ent_t ent_q [N];
  ctg_ent_t ent_n [N];

  logic [N-1:0]        vld_v, done_v, spec_v;
  logic [N-1:0]        dset, dspec, sset, cset;
  logic [N-1:0]        grant_c, kill_c, oldest_c;
  logic [DISP_W-1:0]   disp_en;
  logic [N-1:0][N-1:0] row;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      vld_v[i]  = ent_q[i].vld;
      done_v[i] = ent_q[i].done;
      spec_v[i] = ent_q[i].spec;
    end
  end

  // dispatch is dropped in a squash cycle (R10)
  assign disp_en = disp_vld & {DISP_W{~sq_vld}};

  always_comb begin
    dset = '0; dspec = '0; sset = '0; cset = '0;
    for (int s = 0; s < DISP_W; s++) begin
      if (disp_en[s]) begin
        dset[disp_idx[s*IDX_W +: IDX_W]]  = 1'b1;
        dspec[disp_idx[s*IDX_W +: IDX_W]] = disp_spec[s];
      end
    end
    for (int s = 0; s < SAFE_W; s++)
      if (safe_vld[s]) sset[safe_idx[s*IDX_W +: IDX_W]] = 1'b1;
    for (int s = 0; s < DONE_W; s++)
      if (done_vld[s]) cset[done_idx[s*IDX_W +: IDX_W]] = 1'b1;
  end

  ctg_age_matrix #(.N(N), .DISP_W(DISP_W)) age_i (
    .clk(clk), .rst(rst),
    .base_vld(vld_v & ~grant_c),
    .disp_en(disp_en), .disp_idx(disp_idx),
    .row(row)
  );

  ctg_squash_scan #(.N(N)) scan_i (
    .row(row), .vld(vld_v),
    .sq_vld(sq_vld), .sq_idx(sq_idx), .sq_self(sq_self),
    .kill(kill_c), .oldest(oldest_c)
  );

  ctg_grant_select #(.N(N), .CMT_W(CMT_W)) sel_i (
    .row(row), .vld(vld_v), .done(done_v), .spec(spec_v),
    .block(kill_c), .grant(grant_c)
  );

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_n[i].vld  = (ent_q[i].vld & ~(grant_c[i] | kill_c[i])) | dset[i];
      ent_n[i].done = (ent_q[i].done | (cset[i] & ent_q[i].vld))
                      & ~(grant_c[i] | kill_c[i]) & ~dset[i];
      ent_n[i].spec = (ent_q[i].spec & ~sset[i] & ~(grant_c[i] | kill_c[i]))
                      | dspec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
      commit_grant <= '0;
      oldest_oh    <= '0;
      kill_mask    <= '0;
    end else begin
      for (int i = 0; i < N; i++) ent_q[i] <= ent_n[i];
      commit_grant <= grant_c;
      oldest_oh    <= oldest_c;
      kill_mask    <= kill_c;
    end
  end

  // assertions
  p_grant_cap_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(commit_grant) <= CMT_W);

  p_oldest_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(oldest_oh));

  p_retired_gone_r5: assert property (@(posedge clk) disable iff (rst)
    (commit_grant & vld_v) == '0);

  p_killed_gone_r8: assert property (@(posedge clk) disable iff (rst)
    (kill_mask & vld_v) == '0);

  p_kill_not_granted_r9: assert property (@(posedge clk) disable iff (rst)
    (commit_grant & kill_mask) == '0);

  p_no_disp_on_squash_r10: assert property (@(posedge clk) disable iff (rst)
    $past(sq_vld) && !$past(rst) |-> (vld_v & ~$past(vld_v)) == '0);
endmodule

// File: tb/ctg_commit_tracker_tb_top.sv
`timescale 1ns/1ps
module ctg_commit_tracker_tb_top;
  localparam int N = 8, DISP_W = 2, SAFE_W = 2, DONE_W = 2, CMT_W = 2;
  localparam int IDX_W = $clog2(N);

  logic clk = 1'b0, rst = 1'b1;
  logic [DISP_W-1:0]       disp_vld = '0, disp_spec = '0;
  logic [DISP_W*IDX_W-1:0] disp_idx = '0;
  logic [SAFE_W-1:0]       safe_vld = '0;
  logic [SAFE_W*IDX_W-1:0] safe_idx = '0;
  logic [DONE_W-1:0]       done_vld = '0;
  logic [DONE_W*IDX_W-1:0] done_idx = '0;
  logic                    sq_vld = 1'b0, sq_self = 1'b0;
  logic [IDX_W-1:0]        sq_idx = '0;
  logic [N-1:0]            commit_grant, oldest_oh, kill_mask;

  always #2.5 clk = ~clk;

  ctg_commit_tracker #(.N(N), .DISP_W(DISP_W), .SAFE_W(SAFE_W),
    .DONE_W(DONE_W), .CMT_W(CMT_W)) dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit m_val [N], m_done [N], m_spec [N];
  int m_seq [N];
  int seq_ctr = 0;
  logic [N-1:0] eg, ek, eo;

  task automatic chk(string rq, string what, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%b exp=%b", rq, what, act, exp);
    end
  endtask

  task automatic idle_in();
    disp_vld = '0; disp_spec = '0; safe_vld = '0; done_vld = '0;
    sq_vld = 1'b0; sq_self = 1'b0;
  endtask

  // expected outputs from the model, then model update (age via sequence numbers)
  task automatic model_edge();
    int cnt, best, c, d;
    eg = '0; ek = '0; eo = '0;
    if (sq_vld) begin
      c = int'(sq_idx);
      for (int j = 0; j < N; j++)
        if (m_val[j] && (m_seq[j] > m_seq[c] || (sq_self && j == c) ) && m_val[c]) ek[j] = 1'b1;
    end
    cnt = 0;
    for (int i = 0; i < N; i++) begin
      bit ok;
      ok = m_val[i] && m_done[i] && !m_spec[i] && !ek[i];
      for (int j = 0; j < N; j++)
        if (m_val[j] && m_spec[j] && m_seq[j] < m_seq[i]) ok = 1'b0;
      if (ok && cnt < CMT_W) begin eg[i] = 1'b1; cnt++; end
    end
    best = -1;
    for (int i = 0; i < N; i++)
      if (m_val[i] && (best < 0 || m_seq[i] < m_seq[best])) best = i;
    if (best >= 0) eo[best] = 1'b1;
    // update
    for (int s = 0; s < SAFE_W; s++)
      if (safe_vld[s]) m_spec[safe_idx[s*IDX_W +: IDX_W]] = 1'b0;
    for (int s = 0; s < DONE_W; s++)
      if (done_vld[s] && m_val[done_idx[s*IDX_W +: IDX_W]])
        m_done[done_idx[s*IDX_W +: IDX_W]] = 1'b1;
    for (int i = 0; i < N; i++)
      if (eg[i] || ek[i]) begin m_val[i] = 0; m_done[i] = 0; m_spec[i] = 0; end
    if (!sq_vld)
      for (int s = 0; s < DISP_W; s++)
        if (disp_vld[s]) begin
          d = int'(disp_idx[s*IDX_W +: IDX_W]);
          m_val[d] = 1; m_done[d] = 0; m_spec[d] = disp_spec[s];
          m_seq[d] = seq_ctr++;
        end
  endtask

  task automatic step(string rq);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    chk(rq, "grant", commit_grant, eg);
    chk("R8", "kill", kill_mask, ek);
    chk("R7", "oldest", oldest_oh, eo);
    idle_in();
  endtask

  task automatic disp2(int a, bit sa, int b, bit sb);
    disp_vld = 2'b11; disp_spec = {sb, sa};
    disp_idx = {IDX_W'(b), IDX_W'(a)};
  endtask

  task automatic done2(int a, int b);
    done_vld = 2'b11; done_idx = {IDX_W'(b), IDX_W'(a)};
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL R3 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin m_val[i]=0; m_done[i]=0; m_spec[i]=0; m_seq[i]=0; end
    idle_in();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "grant", commit_grant, '0);
    chk("R1", "kill", kill_mask, '0);
    chk("R1", "oldest", oldest_oh, '0);

    // R2 + R6: slot 0 (idx5, speculative) older than slot 1 (idx2)
    disp2(5, 1, 2, 0);            step("R2");
    done_vld = 2'b01; done_idx = IDX_W*2'(0) | IDX_W'(2); step("R3");
    step("R3");                    // blocked by older speculative idx5
    step("R3");
    safe_vld = 2'b01; safe_idx = SAFE_W*IDX_W'(0) | IDX_W'(5); step("R6");
    step("R6");                    // idx2 retires while idx5 still live
    done_vld = 2'b01; done_idx = DONE_W*IDX_W'(0) | IDX_W'(5); step("R3");
    step("R3");
    step("R5");                    // nothing left, no regrant

    // R4: four completed entries, cap of two, lowest index first
    disp2(6, 0, 1, 0); step("R2");
    disp2(3, 0, 0, 0); step("R2");
    done2(6, 1); step("R4");
    done2(3, 0); step("R4");
    step("R4"); step("R4"); step("R5");

    // R8 + R9: squash of middle entry with replay while older one retires
    disp2(4, 0, 7, 1); step("R2");
    disp2(2, 0, 5, 0); step("R2");
    done2(4, 5); step("R9");
    sq_vld = 1'b1; sq_idx = IDX_W'(7); sq_self = 1'b1;
    disp_vld = 2'b01; disp_idx = '0 | IDX_W'(1);  // R10: dropped
    step("R9");
    step("R8");
    done_vld = 2'b01; done_idx = '0 | IDX_W'(1); step("R10");
    step("R10");                   // idx1 never granted

    // R11: completion on dead index before its dispatch
    done_vld = 2'b01; done_idx = '0 | IDX_W'(6); step("R11");
    disp_vld = 2'b01; disp_idx = '0 | IDX_W'(6); step("R11");
    step("R11"); step("R11");

    // constrained random traffic
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit used [N];
      for (int i = 0; i < N; i++) used[i] = 0;
      for (int s = 0; s < DISP_W; s++) begin
        int d;
        d = int'($urandom_range(N-1));
        if (!m_val[d] && !used[d] && $urandom_range(99) < 45) begin
          used[d] = 1;
          disp_vld[s] = 1'b1;
          disp_spec[s] = ($urandom_range(99) < 50);
          disp_idx[s*IDX_W +: IDX_W] = IDX_W'(d);
        end
      end
      for (int s = 0; s < DONE_W; s++) begin
        done_vld[s] = ($urandom_range(99) < 60);
        done_idx[s*IDX_W +: IDX_W] = IDX_W'($urandom_range(N-1));
      end
      for (int s = 0; s < SAFE_W; s++) begin
        safe_vld[s] = ($urandom_range(99) < 40);
        safe_idx[s*IDX_W +: IDX_W] = IDX_W'($urandom_range(N-1));
      end
      if ($urandom_range(99) < 4) begin
        int c;
        c = int'($urandom_range(N-1));
        if (m_val[c]) begin
          sq_vld = 1'b1; sq_idx = IDX_W'(c); sq_self = ($urandom_range(1) == 1);
        end
      end
      step("R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule